// File: doc/BRIEF.md
# Multi-Channel Countdown Timer

This peripheral holds a parameterised number of independent 64-bit down-counters behind a simple single-cycle register bus. Each channel has a write strobe, an address, write data and read data. Software loads a 64-bit interval into a channel and asks for that interval to be copied into the counter. The channel then counts down, either once or over and over. A 3-bit prescale field slows each channel's count by a power of two.

When a counter expires, the channel latches a pending flag in a shared status register. A shared mask register decides which pending flags reach the single interrupt line. When software turns a channel off, the channel keeps counting for a short fixed window before it stops. A driver that stops a channel can therefore wait a known number of cycles and be sure the channel is quiet.

If the interval is all ones and the channel runs in periodic mode, the channel serves as a free-running down-counter that wraps. A time base can be read from it.

Top module: `cdt_top`

## Requirements
- R1: The register map is as follows. Mask is at 0x00, with bit n for channel n. Pending status is at 0x04. Channel n's group starts at 0x10+0x20*n and holds control at +0x00, interval low at +0x04, interval high at +0x08, count low at +0x0C and count high at +0x10. Control bit 0 is run, bit 1 is load, bits 6:4 are prescale and bit 7 is single-shot. All other control bits, unused mask bits and addresses with no register read as zero. After reset every register reads zero.
- R2: Writing control with bit 1 set copies the full 64-bit interval into the counter on the next clock edge. This happens even when run is 0. Bit 1 then reads back as 0.
- R3: With run set and prescale 0, the counter drops by one on every clock, and the borrow carries from the low word into the high word. With run clear and the stop window over, the counter holds its value.
- R4: A count step taken while the counter is 0 is an expiry. On the same edge it sets the channel's status bit.
- R5: With bit 7 clear, an expiry reloads the interval and counting goes on, so the channel expires once every interval+1 steps.
- R6: With bit 7 set, an expiry leaves the counter at 0 and clears the run bit, which then reads back 0.
- R7: Prescale value p gives one count step every 2^p clocks. The first step comes 2^p clocks after the load edge.
- R8: After software writes run from 1 to 0, the counter takes exactly 2 more steps (at prescale 0) before it stops.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A status bit is set on expiry whatever the mask holds.
- R10: The interrupt output is high exactly when some channel has both its status bit and its mask bit set.
- R11: An all-ones interval with load and run set gives a free-running counter that starts at all ones and counts down across the whole 64-bit range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_rdata | output | 32 | Combinational read data |
| irq_o | output | 1 | Interrupt: OR over channels of status AND mask |

## Verification
The hardest behaviour to reach from the ports is the stop window after run is cleared. The counter must be moving while the write lands, and the only evidence of the window is the count it reaches afterwards. The stimulus loads a large interval, starts the channel at prescale 0 and, some cycles later, writes run low. It reads the count right after that write and again several cycles later, and the two reads must differ by exactly the window length. Single-shot expiry and status clearing are reached by first stopping the periodic channel, so that no new expiry can race the clear.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int DATA_W   = 32;
    localparam int PRE_W    = 3;
    localparam int PSC_W    = (1 << PRE_W) - 1;

    localparam logic [7:0] OFF_MASK   = 8'h00;
    localparam logic [7:0] OFF_STATUS = 8'h04;
    localparam logic [7:0] GRP_BASE   = 8'h10;
    localparam logic [7:0] GRP_STRIDE = 8'h20;
    localparam logic [7:0] SUB_CTRL   = 8'h00;
    localparam logic [7:0] SUB_IVL_LO = 8'h04;
    localparam logic [7:0] SUB_IVL_HI = 8'h08;
    localparam logic [7:0] SUB_CNT_LO = 8'h0C;
    localparam logic [7:0] SUB_CNT_HI = 8'h10;

    typedef struct packed {
        logic             single;
        logic [PRE_W-1:0] pre;
        logic             load;
        logic             run;
    } ctrl_t;

    typedef struct packed {
        logic ctrl;
        logic ivl_lo;
        logic ivl_hi;
    } chan_we_t;

    function automatic logic [7:0] grp_addr(input int n, input logic [7:0] sub);
        return GRP_BASE + GRP_STRIDE * 8'(n) + sub;
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.run    = w[0];
        c.load   = w[1];
        c.pre    = w[6:4];
        c.single = w[7];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w      = '0;
        w[0]   = c.run;
        w[1]   = c.load;
        w[6:4] = c.pre;
        w[7]   = c.single;
        return w;
    endfunction

endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale
    import cdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [PRE_W-1:0] sel,
    output logic             tick
);
    logic [PSC_W-1:0] pcnt_q;
    logic [PSC_W-1:0] mask;

    always_comb begin
        mask = PSC_W'((1 << sel) - 1);
        tick = !clr && ((pcnt_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) pcnt_q <= '0;
        else            pcnt_q <= pcnt_q + 1'b1;
    end

    AST_TICK_DIV1: assert property (@(posedge clk) disable iff (rst)
        (!clr && sel == '0) |-> tick);  // R7

    AST_NO_DOUBLE_TICK: assert property (@(posedge clk) disable iff (rst)
        (tick && sel != '0 && $stable(sel)) |=> !tick);  // R7
endmodule

// File: rtl/cdt_channel.sv
module cdt_channel
    import cdt_pkg::*;
#(
    parameter int CNT_W    = 64,
    parameter int STOP_LAG = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  chan_we_t          we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [CNT_W-1:0]  ivl_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              expire
);
    localparam int LAG_W = $clog2(STOP_LAG + 1);
    localparam int HALF  = CNT_W / 2;

    ctrl_t            ctrl_q;
    ctrl_t            ctrl_w;
    logic [CNT_W-1:0] ivl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [LAG_W-1:0] lag_q;
    logic             active;
    logic             tick;
    logic             psc_clr;

    assign ctrl_w  = ctrl_unpack(wdata);
    assign active  = ctrl_q.run || (lag_q != '0);
    assign psc_clr = ctrl_q.load || !active;
    assign expire  = active && tick && !ctrl_q.load && (cnt_q == '0);
    assign ctrl_rd = ctrl_pack(ctrl_q);
    assign ivl_o   = ivl_q;
    assign cnt_o   = cnt_q;

    cdt_prescale u_psc (
        .clk  (clk),
        .rst  (rst),
        .clr  (psc_clr),
        .sel  (ctrl_q.pre),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ivl_q <= '0;
        end else begin
            if (we.ivl_lo) ivl_q[HALF-1:0]     <= wdata[HALF-1:0];
            if (we.ivl_hi) ivl_q[CNT_W-1:HALF] <= wdata[HALF-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ctrl_q.load) begin
            cnt_q <= ivl_q;
        end else if (active && tick) begin
            if (cnt_q == '0) cnt_q <= ctrl_q.single ? '0 : ivl_q;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            lag_q  <= '0;
        end else if (we.ctrl) begin
            ctrl_q <= ctrl_w;
            lag_q  <= (ctrl_q.run && !ctrl_w.run) ? LAG_W'(STOP_LAG) : '0;
        end else begin
            if (ctrl_q.load)             ctrl_q.load <= 1'b0;
            if (expire && ctrl_q.single) ctrl_q.run  <= 1'b0;
            if (!ctrl_q.run && lag_q != '0) lag_q    <= lag_q - 1'b1;
        end
    end

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.load |=> (cnt_q == $past(ivl_q)));  // R2

    AST_LOAD_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.load && !we.ctrl) |=> !ctrl_q.load);  // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!active && !ctrl_q.load) |=> $stable(cnt_q));  // R3

    AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (rst)
        (expire && ctrl_q.single && !we.ctrl) |=> (!ctrl_q.run && cnt_q == '0));  // R6

    AST_LAG_BOUND: assert property (@(posedge clk) disable iff (rst)
        lag_q <= LAG_W'(STOP_LAG));  // R8
endmodule

// File: rtl/cdt_top.sv
module cdt_top
    import cdt_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int CNT_W    = 64,
    parameter int STOP_LAG = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    localparam int HALF = CNT_W / 2;

    logic [NCH-1:0]     mask_q;
    logic [NCH-1:0]     stat_q;
    logic [NCH-1:0]     expire_v;
    chan_we_t           we_v    [NCH];
    logic [DATA_W-1:0]  ctrl_v  [NCH];
    logic [CNT_W-1:0]   ivl_v   [NCH];
    logic [CNT_W-1:0]   cnt_v   [NCH];

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        always_comb begin
            we_v[n].ctrl   = bus_wr && (bus_addr == grp_addr(n, SUB_CTRL));
            we_v[n].ivl_lo = bus_wr && (bus_addr == grp_addr(n, SUB_IVL_LO));
            we_v[n].ivl_hi = bus_wr && (bus_addr == grp_addr(n, SUB_IVL_HI));
        end

        cdt_channel #(
            .CNT_W    (CNT_W),
            .STOP_LAG (STOP_LAG)
        ) u_ch (
            .clk     (clk),
            .rst     (rst),
            .we      (we_v[n]),
            .wdata   (bus_wdata),
            .ctrl_rd (ctrl_v[n]),
            .ivl_o   (ivl_v[n]),
            .cnt_o   (cnt_v[n]),
            .expire  (expire_v[n])
        );

        AST_EXPIRE_FLAGS: assert property (@(posedge clk) disable iff (rst)
            expire_v[n] |=> stat_q[n]);  // R4
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            stat_q <= '0;
        end else begin
            if (bus_wr && bus_addr == OFF_MASK) mask_q <= bus_wdata[NCH-1:0];
            if (bus_wr && bus_addr == OFF_STATUS)
                stat_q <= (stat_q & ~bus_wdata[NCH-1:0]) | expire_v;
            else
                stat_q <= stat_q | expire_v;
        end
    end

    assign irq_o = |(stat_q & mask_q);

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == OFF_MASK)   bus_rdata[NCH-1:0] = mask_q;
            if (bus_addr == OFF_STATUS) bus_rdata[NCH-1:0] = stat_q;
            for (int n = 0; n < NCH; n++) begin
                if (bus_addr == grp_addr(n, SUB_CTRL))   bus_rdata = ctrl_v[n];
                if (bus_addr == grp_addr(n, SUB_IVL_LO)) bus_rdata = ivl_v[n][HALF-1:0];
                if (bus_addr == grp_addr(n, SUB_IVL_HI)) bus_rdata = ivl_v[n][CNT_W-1:HALF];
                if (bus_addr == grp_addr(n, SUB_CNT_LO)) bus_rdata = cnt_v[n][HALF-1:0];
                if (bus_addr == grp_addr(n, SUB_CNT_HI)) bus_rdata = cnt_v[n][CNT_W-1:HALF];
            end
        end
    end

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_STATUS && bus_wdata[0] && !expire_v[0])
        |=> !stat_q[0]);  // R9

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq_o);  // R10
endmodule

// File: tb/sim_cdt_top.sv
module sim_cdt_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_wr;
    logic        bus_rd;
    logic [31:0] bus_rdata;
    logic        irq_o;
    int          n_run  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    always #4 clk = ~clk;

    cdt_top u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // {address, write data, expected readback}
    localparam logic [71:0] VEC [9] = '{
        {8'h00, 32'hFFFF_FFFF, 32'h0000_000F},
        {8'h14, 32'h1234_5678, 32'h1234_5678},
        {8'h18, 32'hCAFE_F00D, 32'hCAFE_F00D},
        {8'h30, 32'hFFFF_FF7C, 32'h0000_0070},
        {8'h50, 32'h0000_0008, 32'h0000_0000},
        {8'h70, 32'h0000_0080, 32'h0000_0080},
        {8'h08, 32'hDEAD_BEEF, 32'h0000_0000},
        {8'hF0, 32'h1111_1111, 32'h0000_0000},
        {8'h00, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        d        = bus_rdata;
        bus_rd   = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] c0;
        logic [31:0] c1;
        rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        chk_reg("R1 reset mask", 8'h00, 32'h0);
        chk_reg("R1 reset status", 8'h04, 32'h0);
        chk_reg("R1 reset count", 8'h1C, 32'h0);
        chk("R10 reset irq", 32'(irq_o), 32'h0);

        // R1 register map table
        foreach (VEC[i]) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            step(1);
            chk_reg($sformatf("R1 vec%0d", i), VEC[i][71:64], VEC[i][31:0]);
        end
        wr(8'h30, 32'h0); wr(8'h70, 32'h0);

        // R2 load while stopped
        wr(8'h14, 32'd10); wr(8'h18, 32'd0);
        wr(8'h10, 32'h2);
        step(1);
        chk_reg("R2 loaded", 8'h1C, 32'd10);
        chk_reg("R2 load self-clear", 8'h10, 32'h0);
        step(5);
        chk_reg("R3 stopped holds", 8'h1C, 32'd10);

        // R4/R5 periodic, interval 3
        wr(8'h00, 32'h1);
        wr(8'h14, 32'd3);
        wr(8'h10, 32'h3);            // returns after edge k
        step(1); chk_reg("R2 start load", 8'h1C, 32'd3);
        step(1); chk_reg("R3 decrement", 8'h1C, 32'd2);
        step(2); chk_reg("R4 at zero", 8'h1C, 32'd0);
        chk_reg("R4 not yet flagged", 8'h04, 32'h0);
        step(1); chk_reg("R4 flagged", 8'h04, 32'h1);
        chk_reg("R5 reloaded", 8'h1C, 32'd3);
        chk("R10 irq on", 32'(irq_o), 32'h1);
        step(1); chk_reg("R5 continues", 8'h1C, 32'd2);

        // stop, then clear status
        wr(8'h10, 32'h0);
        step(10);
        wr(8'h04, 32'h0);
        chk_reg("R9 zero write keeps", 8'h04, 32'h1);
        wr(8'h04, 32'hF);
        chk_reg("R9 cleared", 8'h04, 32'h0);
        chk("R10 irq off", 32'(irq_o), 32'h0);

        // R6 single-shot on channel 1, masked off
        wr(8'h34, 32'd2); wr(8'h38, 32'd0);
        wr(8'h30, 32'h83);
        step(1); chk_reg("R6 loaded", 8'h3C, 32'd2);
        step(2); chk_reg("R6 at zero", 8'h3C, 32'd0);
        step(5);
        chk_reg("R6 stays zero", 8'h3C, 32'd0);
        chk_reg("R6 run cleared", 8'h30, 32'h80);
        chk_reg("R9 flag despite mask", 8'h04, 32'h2);
        chk("R10 masked", 32'(irq_o), 32'h0);
        wr(8'h00, 32'h2);
        chk("R10 unmasked", 32'(irq_o), 32'h1);
        wr(8'h04, 32'h2);
        chk("R10 cleared", 32'(irq_o), 32'h0);

        // R7 prescale 3 on channel 2
        wr(8'h54, 32'd1000); wr(8'h58, 32'd0);
        wr(8'h50, 32'h33);
        step(8); chk_reg("R7 before first step", 8'h5C, 32'd1000);
        step(1); chk_reg("R7 first step", 8'h5C, 32'd999);
        step(7); chk_reg("R7 holding", 8'h5C, 32'd999);
        step(1); chk_reg("R7 second step", 8'h5C, 32'd998);
        wr(8'h50, 32'h0);

        // R8 stop window on channel 3
        wr(8'h74, 32'd100); wr(8'h78, 32'd0);
        wr(8'h70, 32'h3);
        step(20);
        wr(8'h70, 32'h0);
        rd(8'h7C, c0);
        step(6);
        rd(8'h7C, c1);
        chk("R8 two extra steps", c1, c0 - 32'd2);

        // R3 borrow across halves, channel 0
        wr(8'h14, 32'd1); wr(8'h18, 32'd1);
        wr(8'h10, 32'h3);
        step(1); chk_reg("R3 hi start", 8'h20, 32'd1);
        step(2);
        chk_reg("R3 borrow lo", 8'h1C, 32'hFFFF_FFFF);
        chk_reg("R3 borrow hi", 8'h20, 32'h0);
        wr(8'h10, 32'h0);
        step(4);

        // R11 free-running all ones
        wr(8'h14, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h10, 32'h3);
        step(1); chk_reg("R11 start lo", 8'h1C, 32'hFFFF_FFFF);
        step(1);
        chk_reg("R11 counting lo", 8'h1C, 32'hFFFF_FFFE);
        chk_reg("R11 counting hi", 8'h20, 32'hFFFF_FFFF);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule